// File: doc/BRIEF.md
# Sequential Stream Prefetch Detector

This block sits beside a second-level cache and watches the data read requests (plain gets and get-exclusive requests) that arrive from the first level. For each of the two request kinds it remembers the set index of the previous request and keeps a count of how many times in a row the index has advanced by exactly one. As that run grows, the block issues prefetches for lines further ahead of the current one. The prefetch distance rises in steps of a configurable run length, up to a configurable maximum distance.

Every prefetch carries the command kind of the stream that caused it. A prefetch whose target line falls at or beyond a configured address limit is dropped. A single request can trigger several prefetches. These are held in a small pending set and issued one per cycle, nearest line first. While any are pending, the block refuses new requests.

Top module: `stream_prefetch`

## Requirements
- R1: After reset, `req_ready` is 1, `pf_valid` is 0, and both streams hold a last index of 0 and a run count of 0. The first request to index 1 therefore counts as a successor.
- R2: `req_kind` 2'b00 selects the get stream and 2'b01 selects the get-exclusive stream. Each stream has its own last index and run count, and a request to one stream never changes the other. Kinds 2'b10 and 2'b11 are accepted but change no state and cause no prefetch.
- R3: When `en` is 1 and the index equals the stream's last index plus one (modulo 2^IDX_W), the run count is incremented first and then evaluated. The count saturates at 65535 and does not wrap.
- R4: On every accepted tracked request, the stream's last index becomes the request index. An index that is neither the successor nor equal to the last index clears the run count to 0. A repeat of the last index leaves the run count unchanged and issues nothing.
- R5: On a successor request, for each distance d from 1 to depth-1, a prefetch d lines ahead is produced when range*d <= run <= range*(d+1), with both bounds inclusive.
- R6: On a successor request, a prefetch depth lines ahead is produced when run >= range*depth. A `cfg_depth` above 4 acts as 4. A `cfg_depth` of 0 produces no prefetches.
- R7: The target address is `req_addr` + d*LINE_BYTES. A target at or above `addr_limit` is suppressed, while the other distances of the same request are still issued.
- R8: Pending prefetches are issued one per cycle in ascending distance, starting the cycle after the request is accepted. `pf_excl` is 1 for prefetches from the get-exclusive stream and 0 for the get stream.
- R9: `req_ready` is 0 while prefetches are pending. A `req_valid` pulse in such a cycle is ignored and changes no stream state.
- R10: When `en` is 0, no prefetch is produced, and a successor index is treated like any other index change: the run count clears to 0 and the last index is still updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Streaming enable |
| cfg_range | input | RUN_W | Run length per distance step |
| cfg_depth | input | DEP_W | Maximum prefetch distance in lines |
| addr_limit | input | ADDR_W | Exclusive upper bound of valid addresses |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 00 get, 01 get-exclusive, 1x untracked |
| req_index | input | IDX_W | Set index of the requested line |
| req_addr | input | ADDR_W | Line address of the request |
| req_ready | output | 1 | Block can accept a request |
| pf_valid | output | 1 | A prefetch is presented this cycle |
| pf_addr | output | ADDR_W | Prefetch line address |
| pf_excl | output | 1 | Prefetch is get-exclusive |

## Verification
The assertions assume that `addr_limit`, `cfg_range` and `cfg_depth` do not change while prefetches are pending. Under that assumption, every issued address stays below the limit and the addresses rise strictly within one burst. The stimulus changes configuration only after the queue has drained. It uses line addresses well below 2^32 minus the largest offset, so target sums never wrap.

// File: rtl/stream_prefetch.sv
module stream_prefetch #(
  parameter int IDX_W      = 10,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_DEPTH  = 4,
  parameter int RUN_W      = 16,
  localparam int DEP_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RUN_W-1:0]  cfg_range,
  input  logic [DEP_W-1:0]  cfg_depth,
  input  logic [ADDR_W-1:0] addr_limit,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              pf_excl
);
  localparam int PROD_W = RUN_W + DEP_W + 1;
  localparam int EXT_W  = ADDR_W + 1;

  logic [IDX_W-1:0]     last_q [2];
  logic [RUN_W-1:0]     run_q  [2];
  logic [MAX_DEPTH-1:0] mask_q, hit;
  logic [ADDR_W-1:0]    base_q, pf_off;
  logic                 excl_q;

  wire take    = req_valid && req_ready;
  wire tracked = take && !req_kind[1];
  wire sel     = req_kind[0];

  wire [IDX_W-1:0] last_sel = last_q[sel];
  wire [RUN_W-1:0] run_sel  = run_q[sel];
  wire succ = (req_index == IDX_W'(last_sel + 1'b1));
  wire fire = en && succ;

  wire [RUN_W-1:0] run_inc  = (run_sel == {RUN_W{1'b1}}) ? run_sel : run_sel + 1'b1;
  wire [RUN_W-1:0] run_next = fire ? run_inc :
                              (req_index != last_sel) ? '0 : run_sel;

  wire [DEP_W-1:0]  depth_eff = (cfg_depth > DEP_W'(MAX_DEPTH)) ? DEP_W'(MAX_DEPTH) : cfg_depth;
  wire [PROD_W-1:0] run_ext   = PROD_W'(run_next);

  for (genvar k = 0; k < MAX_DEPTH; k++) begin : g_dist
    wire [PROD_W-1:0] lo     = PROD_W'(cfg_range) * PROD_W'(k + 1);
    wire [PROD_W-1:0] hi     = PROD_W'(cfg_range) * PROD_W'(k + 2);
    wire              inner  = (DEP_W'(k + 1) < depth_eff) && run_ext >= lo && run_ext <= hi;
    wire              outer  = (DEP_W'(k + 1) == depth_eff) && run_ext >= lo;
    wire [EXT_W-1:0]  target = {1'b0, req_addr} + EXT_W'((k + 1) * LINE_BYTES);
    wire              in_rng = target < {1'b0, addr_limit};
    assign hit[k] = fire && (inner || outer) && in_rng;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
      excl_q <= 1'b0;
      for (int s = 0; s < 2; s++) begin
        last_q[s] <= '0;
        run_q[s]  <= '0;
      end
    end else if (tracked) begin
      mask_q      <= hit;
      base_q      <= req_addr;
      excl_q      <= sel;
      last_q[sel] <= req_index;
      run_q[sel]  <= run_next;
    end else begin
      mask_q <= mask_q & (mask_q - 1'b1);
    end
  end

  always_comb begin
    pf_off = '0;
    for (int k = MAX_DEPTH - 1; k >= 0; k--)
      if (mask_q[k]) pf_off = ADDR_W'((k + 1) * LINE_BYTES);
  end

  assign req_ready = (mask_q == '0);
  assign pf_valid  = !req_ready;
  assign pf_addr   = base_q + pf_off;
  assign pf_excl   = excl_q;

  // R7
  bound_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr < addr_limit);

  // R8
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && $past(pf_valid) |-> pf_addr > $past(pf_addr));

  // R8
  kind_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && $past(pf_valid) |-> $stable(pf_excl));

  // R10
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !en |=> req_ready);

  // R3
  get_run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q[0] != $past(run_q[0]) |-> run_q[0] == '0 || run_q[0] == RUN_W'($past(run_q[0]) + 1'b1));

  // R3
  getx_run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q[1] != $past(run_q[1]) |-> run_q[1] == '0 || run_q[1] == RUN_W'($past(run_q[1]) + 1'b1));
endmodule

// File: tb/test_stream_prefetch.sv
module test_stream_prefetch;
  logic        clk = 0, rst_n = 0, en = 0;
  logic [15:0] cfg_range = 0;
  logic [2:0]  cfg_depth = 0;
  logic [31:0] addr_limit = 0;
  logic        req_valid = 0;
  logic [1:0]  req_kind = 0;
  logic [9:0]  req_index = 0;
  logic [31:0] req_addr = 0;
  logic        req_ready, pf_valid, pf_excl;
  logic [31:0] pf_addr;

  stream_prefetch i_stream_prefetch (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  string tag = "R1";
  int m_last[2], m_run[2];
  longint qa[$];
  bit qx[$];

  task automatic compare();
    bit er = (qa.size() == 0);
    total++;
    if (req_ready !== er || pf_valid !== !er ||
        (!er && (pf_addr !== qa[0][31:0] || pf_excl !== qx[0]))) begin
      bad++;
      $display("FAIL %s: actual rdy=%0b pv=%0b addr=%h x=%0b expected rdy=%0b pv=%0b addr=%h x=%0b",
               tag, req_ready, pf_valid, pf_addr, pf_excl, er, !er,
               er ? 32'h0 : qa[0][31:0], er ? 1'b0 : qx[0]);
    end
  endtask

  task automatic go(bit v, bit [1:0] k, int idx, longint addr);
    compare();
    req_valid = v; req_kind = k; req_index = idx[9:0]; req_addr = addr[31:0];
    if (v && qa.size() == 0 && !k[1]) begin
      int s = k[0];
      int li = m_last[s];
      bit sc = (idx == ((li + 1) % 1024));
      if (en && sc) m_run[s] = (m_run[s] == 65535) ? 65535 : m_run[s] + 1;
      else if (idx != li) m_run[s] = 0;
      m_last[s] = idx;
      if (en && sc) begin
        int dep = (cfg_depth > 4) ? 4 : cfg_depth;
        for (int d = 1; d <= dep; d++) begin
          longint lo = longint'(cfg_range) * d;
          longint hi = longint'(cfg_range) * (d + 1);
          bit c = (d < dep) ? (m_run[s] >= lo && m_run[s] <= hi) : (m_run[s] >= lo);
          if (c && addr + d * 64 < longint'(addr_limit)) begin
            qa.push_back(addr + d * 64);
            qx.push_back(s[0]);
          end
        end
      end
    end else if (qa.size() != 0) begin
      void'(qa.pop_front()); void'(qx.pop_front());
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic drain();
    while (qa.size() != 0) go(0, 0, 0, 0);
    go(0, 0, 0, 0);
  endtask

  task automatic issue(bit [1:0] k, int idx, longint addr);
    go(1, k, idx, addr);
    drain();
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #760000;
    bad++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    finish_up();
  end

  initial begin
    m_last = '{0, 0}; m_run = '{0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    go(0, 0, 0, 0);
    en = 1; cfg_range = 2; cfg_depth = 3; addr_limit = 32'h0010_0000;
    tag = "R3 R5 R6 get run";
    for (int i = 1; i <= 12; i++) issue(2'b00, i, 32'h1000 + i * 64);
    tag = "R4 repeat";
    issue(2'b00, 12, 32'h1300);
    issue(2'b00, 13, 32'h1340);
    tag = "R4 jump";
    issue(2'b00, 40, 32'h2000);
    issue(2'b00, 41, 32'h2040);
    tag = "R2 R8 getx interleave";
    for (int i = 1; i <= 8; i++) begin
      issue(2'b01, 100 + i, 32'h8000 + i * 64);
      issue(2'b00, 41 + i, 32'h2040 + i * 64);
    end
    tag = "R2 untracked";
    issue(2'b10, 50, 32'h3000);
    issue(2'b11, 7, 32'h3000);
    issue(2'b00, 50, 32'h2400);
    tag = "R7 limit";
    addr_limit = 32'h0000_1000; cfg_range = 1;
    for (int i = 55; i <= 62; i++) issue(2'b01, i, longint'(i) * 64);
    addr_limit = 32'h0010_0000;
    tag = "R9 backpressure";
    cfg_range = 1; cfg_depth = 4;
    for (int i = 200; i <= 206; i++) begin
      go(1, 2'b00, i, 32'h5000 + i * 64);
      for (int j = 0; j < 4; j++) go(1, 2'b00, 900 + j, 32'h0);
    end
    drain();
    tag = "R6 depth clamp";
    cfg_depth = 7;
    for (int i = 300; i <= 306; i++) issue(2'b01, i, 32'h9000 + i * 64);
    tag = "R6 depth zero";
    cfg_depth = 0;
    for (int i = 307; i <= 310; i++) issue(2'b01, i, 32'h9000 + i * 64);
    tag = "R10 disabled";
    cfg_depth = 2; en = 0;
    for (int i = 311; i <= 314; i++) issue(2'b01, i, 32'h9000 + i * 64);
    en = 1;
    for (int i = 315; i <= 318; i++) issue(2'b01, i, 32'h9000 + i * 64);
    tag = "R3 saturation";
    cfg_range = 16'hFFFF; cfg_depth = 1; addr_limit = 32'hFFFF_FFFF;
    for (int i = 1; i <= 65540; i++) begin
      int ix = (51 + i) % 1024;
      go(1, 2'b00, ix, longint'(ix) * 64);
      while (qa.size() != 0) go(0, 0, 0, 0);
    end
    drain();
    finish_up();
  end
endmodule